// File: doc/BRIEF.md
# Open-Drain Interrupt Line Controller

This block looks after a small set of shared, active-low interrupt lines. Each line has a direction bit. As an input, the line is resynchronised and then qualified: a status bit is latched only when the line has read low on three successive samples, so short glitches are ignored. As an output, the line is pulled low or left floating, in open-drain fashion, from a software-held assert bit. An external pull-up supplies the high level, and the block never drives the line high.

Software reaches four registers through a single-cycle write port and a combinational read port. These hold the direction, the output assert, the sticky status (written with ones to clear) and the interrupt enable. One combined interrupt output is raised while any enabled status bit is set. Lines are numbered 1 to 7, and line k sits at bit k-1 of every register.

Top module: `irq_line_ctrl`

## Requirements
- R1: After reset, every register reads 0 (all lines are inputs), `line_oe` is all zeros and `irq_out` is 0.
- R2: Register select `reg_addr`: 0 = direction (1 = output), 1 = output assert, 2 = status (read, write-1-to-clear), 3 = interrupt enable. Direction, assert and enable read back the last value written. Line k maps to bit k-1.
- R3: A status bit for an input line is set only after the synchronised line has read low on three successive samples. A low that starts right after one rising edge is first seen in status after the sixth rising edge. A low lasting one or two clock cycles sets nothing.
- R4: A set status bit stays set after the line returns high (level-qualified, sticky).
- R5: Writing status with a 1 in a bit clears that bit. Bits written 0 keep their value.
- R6: If a line is still qualified low in the cycle its status bit is cleared, the bit remains set.
- R7: `line_oe[i]` is 1 exactly when direction bit i and assert bit i are both 1. `line_out` is always 0, so the line is pulled low or released and never driven high.
- R8: A line configured as an output never sets its status bit, even while the line reads low.
- R9: `irq_out` is 1 exactly when some bit is set in both status and enable (combinational from those registers in the default build).
- R10: Lines are qualified independently: a low on some lines sets exactly those status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 7 | Write data, bit k-1 = line k |
| reg_rdata | output | 7 | Read data of selected register |
| line_in | input | 7 | Sampled level of each line |
| line_oe | output | 7 | Pad output enable per line |
| line_out | output | 7 | Pad output value (always low) |
| irq_out | output | 1 | Combined enabled interrupt |

## Verification
The bench builds the default configuration: seven lines, a two-stage synchroniser, a three-sample qualifier and a combinational interrupt output. At this width every one of the 128 values of direction, assert and enable can be written and read back, and the output-enable mapping can be swept over all direction masks. The enable sweep is repeated against several latched status patterns. Every line is driven with low pulses of one to four cycles, which reaches the exact qualification threshold and the six-edge latency on each line.

// File: rtl/irq_line_pkg.sv
package irq_line_pkg;
   typedef enum logic [1:0] {
      SEL_DIR  = 2'd0,
      SEL_ASRT = 2'd1,
      SEL_STAT = 2'd2,
      SEL_EN   = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
   parameter int WIDTH  = 7,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= '1;
      end else begin
         stg[0] <= async_i;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      end
   end

   assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/irq_line_qual.sv
module irq_line_qual #(
   parameter int DEPTH = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic block_i,
   input  logic samp_i,
   output logic qual_o
);
   logic [DEPTH-1:0] hist;

   generate
      if (DEPTH == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       hist <= '1;
            else if (block_i) hist <= '1;
            else              hist <= samp_i;
         end
      end else begin : g_shift
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       hist <= '1;
            else if (block_i) hist <= '1;
            else              hist <= {hist[DEPTH-2:0], samp_i};
         end
      end
   endgenerate

   assign qual_o = ~|hist;

   // R3: a qualified low needs the newest sample to have been low
   p_qual_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      qual_o |-> !$past(samp_i));
endmodule

// File: rtl/irq_line_regs.sv
module irq_line_regs
   import irq_line_pkg::*;
#(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         reg_wr,
   input  logic [1:0]   reg_addr,
   input  logic [N-1:0] reg_wdata,
   input  logic [N-1:0] qual_i,
   output logic [N-1:0] dir_o,
   output logic [N-1:0] asrt_o,
   output logic [N-1:0] en_o,
   output logic [N-1:0] stat_o,
   output logic [N-1:0] rdata_o
);
   logic [N-1:0] dir_q, asrt_q, en_q, stat_q;
   logic [N-1:0] clr_vec, set_vec;

   assign clr_vec = (reg_wr && reg_addr == SEL_STAT) ? reg_wdata : '0;
   assign set_vec = qual_i & ~dir_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         asrt_q <= '0;
         en_q   <= '0;
         stat_q <= '0;
      end else begin
         if (reg_wr && reg_addr == SEL_DIR)  dir_q  <= reg_wdata;
         if (reg_wr && reg_addr == SEL_ASRT) asrt_q <= reg_wdata;
         if (reg_wr && reg_addr == SEL_EN)   en_q   <= reg_wdata;
         stat_q <= (stat_q & ~clr_vec) | set_vec;
      end
   end

   always_comb begin
      case (reg_addr)
         SEL_DIR:  rdata_o = dir_q;
         SEL_ASRT: rdata_o = asrt_q;
         SEL_STAT: rdata_o = stat_q;
         default:  rdata_o = en_q;
      endcase
   end

   assign dir_o  = dir_q;
   assign asrt_o = asrt_q;
   assign en_o   = en_q;
   assign stat_o = stat_q;

   // R3: a status bit rises only after its line was qualified
   p_set_needs_qual_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_q & ~$past(stat_q) & ~$past(qual_i)) == '0));
   // R4: a status bit falls only through a clear write
   p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(stat_q) & ~stat_q & ~$past(clr_vec)) == '0));
   // R5: a cleared bit that was not requalified reads 0
   p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == SEL_STAT) |=>
         ((stat_q & $past(reg_wdata) & ~$past(qual_i)) == '0));
   // R8: output lines never raise status
   p_out_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_q & ~$past(stat_q) & $past(dir_q)) == '0));
endmodule

// File: rtl/irq_line_ctrl.sv
module irq_line_ctrl
   import irq_line_pkg::*;
#(
   parameter int NUM_LINES   = 7,
   parameter int SYNC_STAGES = 2,
   parameter int QUAL_DEPTH  = 3,
   parameter bit REG_IRQ     = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic [1:0]           reg_addr,
   input  logic [NUM_LINES-1:0] reg_wdata,
   output logic [NUM_LINES-1:0] reg_rdata,
   input  logic [NUM_LINES-1:0] line_in,
   output logic [NUM_LINES-1:0] line_oe,
   output logic [NUM_LINES-1:0] line_out,
   output logic                 irq_out
);
   localparam int N = NUM_LINES;

   generate
      if (N < 1 || N > 32) begin : g_bad_n
         $error("irq_line_ctrl: NUM_LINES must be 1..32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("irq_line_ctrl: SYNC_STAGES must be at least 2");
      end
      if (QUAL_DEPTH < 1 || QUAL_DEPTH > 16) begin : g_bad_qual
         $error("irq_line_ctrl: QUAL_DEPTH must be 1..16");
      end
   endgenerate

   logic [N-1:0] line_sync, qual_vec;
   logic [N-1:0] dir_v, asrt_v, en_v, stat_v;
   logic         irq_any;

   irq_line_sync #(.WIDTH(N), .STAGES(SYNC_STAGES)) sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (line_in),
      .sync_o  (line_sync)
   );

   for (genvar g = 0; g < N; g++) begin : g_qual
      irq_line_qual #(.DEPTH(QUAL_DEPTH)) qual_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .block_i (dir_v[g]),
         .samp_i  (line_sync[g]),
         .qual_o  (qual_vec[g])
      );
   end

   irq_line_regs #(.N(N)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .qual_i    (qual_vec),
      .dir_o     (dir_v),
      .asrt_o    (asrt_v),
      .en_o      (en_v),
      .stat_o    (stat_v),
      .rdata_o   (reg_rdata)
   );

   assign line_oe  = dir_v & asrt_v;
   assign line_out = '0;
   assign irq_any  = |(stat_v & en_v);

   generate
      if (REG_IRQ) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_any;
         end
         assign irq_out = irq_q;
      end else begin : g_irq_comb
         assign irq_out = irq_any;
      end
   endgenerate

   // R7: a line is pulled low only while it is an output
   p_oe_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((line_oe & ~reg_rdata) == '0) || (reg_addr != SEL_DIR));
endmodule

// File: tb/irq_line_ctrl_tb.sv
`timescale 1ns/1ps
module irq_line_ctrl_tb_top;
   localparam int N = 7;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_wr = 1'b0;
   logic [1:0]   reg_addr = 2'd0;
   logic [N-1:0] reg_wdata = '0;
   logic [N-1:0] reg_rdata;
   logic [N-1:0] line_in, line_oe, line_out;
   logic [N-1:0] ext_drv = '1;
   logic         irq_out;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   for (genvar g = 0; g < N; g++) begin : g_wire
      assign line_in[g] = line_oe[g] ? line_out[g] : ext_drv[g];
   end

   irq_line_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_in(line_in),
      .line_oe(line_oe), .line_out(line_out), .irq_out(irq_out)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int k = 0; k < n; k++) @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
      @(posedge clk); #1;
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
      reg_addr = a; #1;
      d = reg_rdata;
   endtask

   logic [N-1:0] rv;

   initial begin
      #(200000 * 5);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(2);
      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(a[1:0], rv);
         check("R1 register after reset", rv, 0);
      end
      check("R1 line_oe after reset", line_oe, 0);
      check("R1 irq_out after reset", irq_out, 0);

      // R2 exhaustive readback of direction (with assert 0), assert, enable
      for (int v = 0; v < 128; v++) begin
         wr(2'd1, v[N-1:0]); rd(2'd1, rv); check("R2 assert readback", rv, v);
         wr(2'd3, v[N-1:0]); rd(2'd3, rv); check("R2 enable readback", rv, v);
      end
      wr(2'd1, '0);
      for (int v = 0; v < 128; v++) begin
         wr(2'd0, v[N-1:0]); rd(2'd0, rv); check("R2 direction readback", rv, v);
         check("R7 oe off while assert clear", line_oe, 0);
      end
      wr(2'd0, '0); wr(2'd3, '0);

      // R7/R8 sweep over direction masks with every assert bit set
      wr(2'd1, '1);
      for (int v = 0; v < 128; v++) begin
         wr(2'd0, v[N-1:0]);
         step(4);
         check("R7 line_oe equals dir&assert", line_oe, v);
         check("R7 line_out never high", line_out, 0);
      end
      wr(2'd0, '0); wr(2'd1, '0);
      step(8);
      rd(2'd2, rv);
      check("R8 self-driven lows left status clear", rv, 0);

      // R8 long self-driven low on an output line
      wr(2'd0, 7'h10); wr(2'd1, 7'h10);
      step(20);
      check("R8 line reads low", line_in[4], 0);
      rd(2'd2, rv);
      check("R8 output line status stays clear", rv, 0);
      wr(2'd1, '0); step(4); wr(2'd0, '0); step(8);
      rd(2'd2, rv);
      check("R8 status clear after return to input", rv, 0);

      // R3 exact latency on line 4 (bit 3)
      ext_drv[3] = 1'b0;
      step(5); rd(2'd2, rv);
      check("R3 not yet set after five edges", rv, 0);
      step(1); rd(2'd2, rv);
      check("R3 set after sixth edge", rv, 7'h08);
      ext_drv[3] = 1'b1;
      step(8); rd(2'd2, rv);
      check("R4 sticky after release", rv, 7'h08);
      wr(2'd2, 7'h77); rd(2'd2, rv);
      check("R5 zero bits keep value", rv, 7'h08);
      wr(2'd2, 7'h08); rd(2'd2, rv);
      check("R5 write one clears", rv, 0);

      // R6 clear while still held low
      ext_drv[0] = 1'b0;
      step(10);
      wr(2'd2, 7'h01); rd(2'd2, rv);
      check("R6 clear while low keeps set", rv, 7'h01);
      ext_drv[0] = 1'b1;
      step(8);
      wr(2'd2, 7'h01); rd(2'd2, rv);
      check("R6 clear after release", rv, 0);

      // R3/R10 pulse width sweep on every line
      for (int p = 0; p < N; p++) begin
         for (int w = 1; w <= 4; w++) begin
            ext_drv[p] = 1'b0;
            step(w);
            ext_drv[p] = 1'b1;
            step(8);
            rd(2'd2, rv);
            check($sformatf("R3 R10 line %0d pulse %0d", p + 1, w), rv,
                  (w >= 3) ? (32'd1 << p) : 32'd0);
            wr(2'd2, '1);
         end
      end

      // R9/R10 enable sweep against several status patterns
      begin
         logic [N-1:0] pats [5];
         pats[0] = 7'h01; pats[1] = 7'h40; pats[2] = 7'h55;
         pats[3] = 7'h2A; pats[4] = 7'h7F;
         for (int s = 0; s < 5; s++) begin
            ext_drv = ~pats[s];
            step(8);
            ext_drv = '1;
            step(8);
            rd(2'd2, rv);
            check("R10 independent status pattern", rv, pats[s]);
            for (int e = 0; e < 128; e++) begin
               wr(2'd3, e[N-1:0]);
               check("R9 irq_out", irq_out, ((pats[s] & e[N-1:0]) != 0) ? 1 : 0);
            end
            wr(2'd3, '1);
            wr(2'd2, '1);
            check("R9 irq_out drops after clear", irq_out, 0);
         end
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule